// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Store Buffer

This block is a direct-mapped cache that sits between a processor and the next level of memory. It holds 1024 lines of one 32-bit word each. Every store goes into a four-entry write queue that drains to memory on its own. The processor therefore never waits for memory on a store unless that queue is full. A read that misses stalls the processor. The cache then fetches the word, installs it and returns it.

A byte address is split into three fields. Bits 31..12 form the tag, bits 11..2 pick the line, and bits 1..0 select a byte inside the word; the cache does not use those two bits. The `alloc_mode` pin sets how a store that misses is handled. When it is 1, the store writes its word, tag and valid bit straight into the indexed line without any hit check. When it is 0, the store leaves the cache data untouched, clears the indexed line's valid bit and goes only to the write queue.

All three data paths use valid/ready handshakes. On the processor side, the processor holds `req_valid` and every request field stable until `req_ready` is high at a clock edge. For a read, `rsp_rdata` is valid in that same cycle. The memory read request holds its address until `mem_rd_ready` is high, and the returned word arrives on `mem_rsp_valid` as a single-cycle pulse. The memory write port holds its address and data while `mem_wr_ready` is low. `alloc_mode` is a plain control pin that is sampled on each store.

Top module: `wt_cache`

## Requirements
- R1: A read whose line is valid and whose tag equals address bits 31..12 completes with `req_ready` high in the cycle it is presented, returns the line's word, and issues no memory read.
- R2: After reset every line is invalid, so the first read of any address misses. `mem_rd_valid` and `mem_wr_valid` are low after reset.
- R3: A read miss holds `req_ready` low and issues one memory read of the request address. The returned word is installed with its tag and valid bit, and the request then completes returning that word, so a repeat read hits.
- R4: A store that hits writes the new word into the line and also places an entry in the write queue, so a later read of that address hits and returns the new word.
- R5: A store is accepted in the cycle it is presented whenever fewer than 4 entries are queued. With 4 entries queued, `req_ready` stays low for the store until an entry drains.
- R6: Queued stores leave on the memory write port in the order they were accepted, one per `mem_wr_valid`/`mem_wr_ready` handshake, each carrying its byte address and data. Address and data hold steady while the port is stalled.
- R7: With `alloc_mode`=1, a store that misses installs its word, tag and valid bit, so a following read of that address hits with the stored word.
- R8: With `alloc_mode`=0, a store that misses leaves the word out of the cache and invalidates the indexed line. A read of the address previously held there then misses, and a read of the stored address also misses.
- R9: A read miss does not raise `mem_rd_valid` until the write queue is empty, so it returns a queued store's data rather than stale memory.
- R10: Address bits 1..0 play no part in lookup. Two addresses that differ only in those bits hit on the same line and return the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_mode | input | 1 | 1: allocate on store miss; 0: bypass and invalidate |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request completes this cycle |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Load data, valid with req_ready on a load |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | 32 | Returned word |
| mem_wr_valid | output | 1 | Write queue head is presented |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |

## Verification
The hardest case to reach from the ports is a read miss that arrives while the write queue still holds a store to the same word. Only the ordering rule stops that read from fetching stale memory. The bench reaches it by holding `mem_wr_ready` low and setting `alloc_mode` to 0. It then stores to a word that is not cached, so the new data sits only in the queue, and reads that word at once. A timed background release of the write port lets the queue drain, and the read must return the stored value. A full queue is reached the same way: the write port is held stalled while four stores go in. The fifth store must then wait, and the drain order is checked once the port is released.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_RDREQ,
    ST_RDWAIT
  } ctrl_state_t;
endpackage

// File: rtl/wt_cache_store.sv
module wt_cache_store #(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 20,
  parameter int INDEX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  output logic               lu_valid,
  output logic [TAG_W-1:0]   lu_tag,
  output logic [DATA_W-1:0]  lu_data,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               inv_en
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // valid bits carry reset; tag and data arrays do not need it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
    end else if (inv_en) begin
      valid_q[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]  <= wr_tag;
      data_q[idx] <= wr_data;
    end
  end

  assign lu_valid = valid_q[idx];
  assign lu_tag   = tag_q[idx];
  assign lu_data  = data_q[idx];
endmodule

// File: rtl/wt_cache_wbuf.sv
module wt_cache_wbuf #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       out_valid,
  output logic [W-1:0]               out_data,
  input  logic                       out_ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;
  assign out_valid = !empty;
  assign out_data  = slot_q[rd_ptr_q];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_ptr_q] <= push_data;
  end
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_mode,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              lu_valid,
  input  logic [TAG_W-1:0]  lu_tag,
  output logic              st_wr_en,
  output logic [TAG_W-1:0]  st_wr_tag,
  output logic [DATA_W-1:0] st_wr_data,
  output logic              st_inv_en,
  output logic              wb_push,
  input  logic              wb_full,
  input  logic              wb_empty,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  ctrl_state_t state_q, state_d;
  logic hit, idle, store_go, fill_go;

  assign idle     = (state_q == ST_IDLE);
  assign hit      = lu_valid && (lu_tag == req_tag);
  assign store_go = idle && req_valid && req_we && !wb_full;
  assign fill_go  = (state_q == ST_RDWAIT) && mem_rsp_valid;

  always_comb begin
    req_ready = 1'b0;
    if (idle) req_ready = req_we ? !wb_full : hit;
  end

  // store path: allocate mode writes unconditionally, bypass mode only on hit
  always_comb begin
    st_wr_en   = 1'b0;
    st_inv_en  = 1'b0;
    st_wr_tag  = req_tag;
    st_wr_data = req_wdata;
    if (store_go) begin
      st_wr_en  = alloc_mode || hit;
      st_inv_en = !alloc_mode && !hit;
    end else if (fill_go) begin
      st_wr_en   = 1'b1;
      st_wr_data = mem_rsp_data;
    end
  end

  assign wb_push      = store_go;
  assign mem_rd_valid = (state_q == ST_RDREQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (req_valid && !req_we && !hit)
          state_d = wb_empty ? ST_RDREQ : ST_DRAIN;
      ST_DRAIN:  if (wb_empty)      state_d = ST_RDREQ;
      ST_RDREQ:  if (mem_rd_ready)  state_d = ST_RDWAIT;
      ST_RDWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int INDEX_W  = 10,
  parameter int OFFSET_W = 2,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int TAG_W  = ADDR_W - INDEX_W - OFFSET_W;
  localparam int ENT_W  = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WB_DEPTH + 1);

  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   req_tag, lu_tag, st_wr_tag;
  logic [DATA_W-1:0]  st_wr_data;
  logic               lu_valid, st_wr_en, st_inv_en;
  logic               wb_push, wb_full, wb_empty;
  logic [CNT_W-1:0]   wb_count;
  logic [ENT_W-1:0]   wb_head;

  assign idx     = req_addr[OFFSET_W +: INDEX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  wt_cache_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .INDEX_W(INDEX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .lu_valid(lu_valid), .lu_tag(lu_tag), .lu_data(rsp_rdata),
    .wr_en(st_wr_en), .wr_tag(st_wr_tag), .wr_data(st_wr_data),
    .inv_en(st_inv_en)
  );

  wt_cache_wbuf #(.W(ENT_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wb_push), .push_data({req_addr, req_wdata}),
    .full(wb_full), .empty(wb_empty), .count(wb_count),
    .out_valid(mem_wr_valid), .out_data(wb_head), .out_ready(mem_wr_ready)
  );

  assign mem_wr_addr = wb_head[ENT_W-1 -: ADDR_W];
  assign mem_wr_data = wb_head[DATA_W-1:0];
  assign mem_rd_addr = req_addr;

  wt_cache_ctrl #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_mode(alloc_mode),
    .req_valid(req_valid), .req_we(req_we), .req_tag(req_tag),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .lu_valid(lu_valid), .lu_tag(lu_tag),
    .st_wr_en(st_wr_en), .st_wr_tag(st_wr_tag), .st_wr_data(st_wr_data),
    .st_inv_en(st_inv_en),
    .wb_push(wb_push), .wb_full(wb_full), .wb_empty(wb_empty),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic [CNT_W-1:0]  wb_count
);
  // R9
  rd_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !mem_wr_valid);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R6
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready && !(req_valid && req_we && req_ready) |=>
      int'(wb_count) == int'($past(wb_count)) - 1);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && req_ready |-> int'(wb_count) < WB_DEPTH);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R1
  hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_we && req_ready |-> !mem_rd_valid);
endmodule

bind wt_cache wt_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_ready(req_ready), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .wb_count(wb_count)
);

// File: tb/wt_cache_test.sv
module wt_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_mode = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  int checks = 0;
  int failures = 0;
  logic wr_stall = 1'b0;

  always #2 clk = ~clk;

  wt_cache uut (
    .clk(clk), .rst_n(rst_n), .alloc_mode(alloc_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  // memory model
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int          log_n = 0;
  int          rd_count = 0;
  logic        rd_busy = 1'b0;
  int          rd_delay = 0;
  logic [31:0] rd_addr_l = '0;

  function automatic logic [31:0] memval(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (mem_model.exists(w)) return mem_model[w];
    return w ^ 32'h5A5A_0000;
  endfunction

  assign mem_rd_ready = 1'b1;
  assign mem_wr_ready = !wr_stall;

  always @(posedge clk) begin
    if (mem_wr_valid && mem_wr_ready) begin
      mem_model[{mem_wr_addr[31:2], 2'b00}] = mem_wr_data;
      if (log_n < 64) begin
        log_addr[log_n] = mem_wr_addr;
        log_data[log_n] = mem_wr_data;
      end
      log_n++;
    end
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_rd_valid && mem_rd_ready) begin
      rd_busy   <= 1'b1;
      rd_delay  <= 2;
      rd_addr_l <= mem_rd_addr;
      rd_count  <= rd_count + 1;
    end else if (rd_busy) begin
      if (rd_delay == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= memval(rd_addr_l);
        rd_busy       <= 1'b0;
      end
      rd_delay <= rd_delay - 1;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [31:0] exp,
                         input bit exp_hit, input string rq);
    int cyc = 0;
    logic [31:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; cyc++;
    end
    got = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(got == exp, {rq, " read data"}, got, exp);
    check((cyc == 0) == exp_hit, {rq, " hit/miss"}, 32'(cyc == 0), 32'(exp_hit));
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                          input string rq);
    int cyc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; cyc++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0;
    check(cyc == 0, {rq, " store accepted at once"}, 32'(cyc), 32'd0);
  endtask

  task automatic wait_drain();
    @(negedge clk);
    while (mem_wr_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!mem_rd_valid, "R2 rd idle after reset", 32'(mem_rd_valid), 0);
    check(!mem_wr_valid, "R2 wr idle after reset", 32'(mem_wr_valid), 0);
    do_read(32'h0000_0100, memval(32'h100), 1'b0, "R2 R3 first read");
    do_read(32'h0000_0100, memval(32'h100), 1'b1, "R1 R3 repeat read");
    do_read(32'h0000_0103, memval(32'h100), 1'b1, "R10 offset ignored");
  endtask

  task automatic t_tag_conflict();
    do_read(32'h0000_1100, memval(32'h1100), 1'b0, "R1 tag mismatch");
    do_read(32'h0000_0100, memval(32'h100), 1'b0, "R1 evicted line");
  endtask

  task automatic t_store_hit();
    int n0;
    alloc_mode = 1'b1;
    n0 = log_n;
    do_write(32'h0000_0100, 32'hCAFE_0001, "R5 R4");
    do_read(32'h0000_0100, 32'hCAFE_0001, 1'b1, "R4 store hit");
    wait_drain();
    check(log_n == n0 + 1, "R4 one queued entry", 32'(log_n - n0), 1);
    check(log_addr[n0] == 32'h100 && log_data[n0] == 32'hCAFE_0001,
          "R6 write port contents", log_data[n0], 32'hCAFE_0001);
  endtask

  task automatic t_alloc_miss();
    alloc_mode = 1'b1;
    do_write(32'h0000_2200, 32'hBEEF_0002, "R7");
    do_read(32'h0000_2200, 32'hBEEF_0002, 1'b1, "R7 allocate on store miss");
    wait_drain();
  endtask

  task automatic t_bypass();
    alloc_mode = 1'b0;
    do_read(32'h0000_0300, memval(32'h300), 1'b0, "R8 prefill");
    do_write(32'h0000_5300, 32'hD00D_0003, "R8");
    do_read(32'h0000_0300, memval(32'h300), 1'b0, "R8 line invalidated");
    do_read(32'h0000_5300, 32'hD00D_0003, 1'b0, "R8 R9 bypassed store");
    do_write(32'h0000_5300, 32'hD00D_0004, "R8 hit store");
    do_read(32'h0000_5300, 32'hD00D_0004, 1'b1, "R4 hit store in bypass mode");
    wait_drain();
  endtask

  task automatic t_full_fifo();
    int n0;
    int stalled = 0;
    alloc_mode = 1'b1;
    wait_drain();
    n0 = log_n;
    wr_stall = 1'b1;
    for (int i = 0; i < 4; i++)
      do_write(32'h0000_4000 + 32'(i * 4), 32'h1000_0000 + 32'(i), "R5 fill queue");
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 32'h0000_4010;
    req_wdata = 32'h1000_0004;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (req_ready) stalled++;
      @(negedge clk);
    end
    check(stalled == 0, "R5 full queue stalls store", 32'(stalled), 0);
    wr_stall = 1'b0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0;
    wait_drain();
    check(log_n == n0 + 5, "R6 entries drained", 32'(log_n - n0), 5);
    for (int i = 0; i < 5; i++)
      check(log_addr[n0 + i] == 32'h0000_4000 + 32'(i * 4) &&
            log_data[n0 + i] == 32'h1000_0000 + 32'(i),
            "R6 drain order", log_data[n0 + i], 32'h1000_0000 + 32'(i));
  endtask

  task automatic t_order();
    int r0;
    alloc_mode = 1'b0;
    wr_stall = 1'b1;
    do_write(32'h0000_7040, 32'hABCD_0009, "R9 queued store");
    r0 = rd_count;
    fork
      begin
        repeat (8) @(negedge clk);
        check(rd_count == r0, "R9 no read before drain", 32'(rd_count - r0), 0);
        wr_stall = 1'b0;
      end
    join_none
    do_read(32'h0000_7040, 32'hABCD_0009, 1'b0, "R9 read behind store");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tag_conflict();
    t_store_hit();
    t_alloc_miss();
    t_bypass();
    t_full_fifo();
    t_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule